// File: doc/BRIEF.md
# SDRAM Write Command Sequencer

This block sits on the controller side of a graphics-class DDR SDRAM and turns a stream of column and precharge requests into command-pin activity. Each request names an operation (write, read or precharge), a bank, a column address and an auto-precharge flag. The block places the column bits and the flag into their fixed address-pin positions and drives the chip-select, row-strobe, column-strobe and write-enable pins. Every command appears on the clock after the request is accepted. When there is no command, the pins hold a no-operation pattern.

The sequencer owns the write timing rules. A write burst may not be cut short by any later command, so column commands are spaced by the number of four-beat prefetch groups in a burst. A precharge to a bank is held back until that bank's latest burst has finished and the write-recovery time has then run out. Requests use a valid/ready handshake, and ready stays low while the head request would break a rule. A precharge to a bank whose latest write asked for auto-precharge is accepted but dropped, because the device closes that row by itself.

Top module: `wr_cmd_seq`

## Requirements
- R1: After a synchronous reset, and on every cycle that follows a clock edge with no accepted request, the pins show NOP: cs_n=0, ras_n=1, cas_n=1, we_n=1, with address and bank at zero.
- R2: An accepted request drives its command on the next cycle. The pin patterns {cs_n,ras_n,cas_n,we_n} are WRITE=0100, READ=0101 and PRECHARGE=0010. req_op encodes 0=write, 1=read, 2=precharge.
- R3: Column and read commands carry column bits 7..0 on address pins 7..0 and column bit 8 on address pin 9. Address pins 10 and 11 are driven low, and the bank field carries req_bank. A precharge carries its bank with the address pins at zero.
- R4: Address pin 8 of every write and read command equals the request's auto-precharge flag.
- R5: Two WRITEs are at least BURST_LEN/4 clock cycles apart. A second write is accepted on exactly the first edge that meets this spacing.
- R6: A READ may follow a WRITE with the same column spacing as R5 and no further delay.
- R7: A PRECHARGE to a bank is accepted no earlier than WL + BURST_LEN/4 + TWR cycles after that bank's last WRITE was accepted, and is accepted on that edge if it is waiting.
- R8: Recovery in one bank does not delay a PRECHARGE to a bank that has no write in flight.
- R9: A PRECHARGE to a bank whose most recent WRITE had the auto-precharge flag set is accepted at once and is ignored: the pins show NOP on the following cycle.
- R10: Operation code 3 is accepted at once and produces NOP.
- R11: A new WRITE to a bank restarts that bank's recovery window from the new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken on this edge |
| req_op | input | 2 | 0 write, 1 read, 2 precharge, 3 reserved |
| req_bank | input | BANK_W (2) | Target bank |
| req_col | input | COL_W (9) | Column address |
| req_ap | input | 1 | Auto-precharge flag |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W (12) | Address pins |
| sd_ba | output | BANK_W (2) | Bank pins |

## Verification
A stuck or off-by-one spacing counter shows up at req_ready within the burst window that follows a write. It appears either as ready rising a cycle early or as a command delayed by a cycle. A wrong per-bank recovery count shows up at the precharge handshake exactly WL+BURST_LEN/4+TWR edges after the write. A stale auto-precharge mark turns the next precharge to that bank into a real command, or into a NOP, on the cycle after acceptance. The reference model compares ready and every pin on every cycle, so each of these faults appears in the cycle it first affects.

// File: rtl/wr_seq_pkg.sv
package wr_seq_pkg;
  // request operation codes
  localparam logic [1:0] OP_WRITE = 2'd0;
  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_PRE   = 2'd2;
  localparam logic [1:0] OP_RSVD  = 2'd3;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PINS_NOP   = 4'b0111;
  localparam logic [3:0] PINS_WRITE = 4'b0100;
  localparam logic [3:0] PINS_READ  = 4'b0101;
  localparam logic [3:0] PINS_PRE   = 4'b0010;
endpackage

// File: rtl/wr_col_spacer.sv
// Column-command spacing: a write burst of NIB nibbles blocks the column
// bus for NIB cycles counted from its command.
module wr_col_spacer #(
  parameter int NIB = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic col_hit,
  output logic col_ok
);
  localparam int GW = (NIB > 1) ? $clog2(NIB) : 1;

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
    end else if (wr_hit) begin
      gap_q <= GW'(NIB - 1);
    end else if (gap_q != '0) begin
      gap_q <= gap_q - GW'(1);
    end
  end

  assign col_ok = (gap_q == '0);

  assert_col_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    col_hit |-> gap_q == '0);

  assert_gap_load_R5: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> gap_q == GW'(NIB - 1));
endmodule

// File: rtl/wr_bank_recovery.sv
// Per-bank tracker: counts down to the last data nibble of the bank's
// latest burst, then runs the write-recovery counter.
module wr_bank_recovery #(
  parameter int WL  = 3,
  parameter int NIB = 2,
  parameter int TWR = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic wr_ap,
  input  logic pre_hit,
  output logic pre_ok,
  output logic ap_closed
);
  localparam int SPAN = WL + NIB - 1;
  localparam int BW   = $clog2(SPAN + 1);
  localparam int TW   = $clog2(TWR + 1);

  logic [BW-1:0] burst_q;
  logic [TW-1:0] twr_q;
  logic          ap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_q <= '0;
      twr_q   <= '0;
      ap_q    <= 1'b0;
    end else if (wr_hit) begin
      burst_q <= BW'(SPAN);
      twr_q   <= '0;
      ap_q    <= wr_ap;
    end else begin
      if (burst_q != '0) burst_q <= burst_q - BW'(1);
      if (burst_q == BW'(1))  twr_q <= TW'(TWR);
      else if (twr_q != '0)   twr_q <= twr_q - TW'(1);
    end
  end

  assign pre_ok    = (burst_q == '0) && (twr_q == '0);
  assign ap_closed = ap_q;

  assert_pre_after_twr_R7: assert property (@(posedge clk) disable iff (rst)
    pre_hit |-> (burst_q == '0 && twr_q == '0));

  assert_twr_load_R7: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && burst_q == BW'(1)) |=> twr_q == TW'(TWR));

  assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (burst_q == BW'(SPAN) && twr_q == '0));
endmodule

// File: rtl/wr_cmd_seq.sv
module wr_cmd_seq
  import wr_seq_pkg::*;
#(
  parameter int BANKS     = 4,
  parameter int COL_W     = 9,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 8,
  parameter int BURST_LEN = 8,
  parameter int WL        = 3,
  parameter int TWR       = 4,
  localparam int BANK_W   = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_ap,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_ba
);
  localparam int NIB = BURST_LEN / 4;

  logic              fire, is_wr, is_rd, is_pre;
  logic              col_ok, ap_sel, pre_ok_sel;
  logic [BANKS-1:0]  bank_sel, pre_ok, ap_closed;
  logic [ADDR_W-1:0] addr_pack;
  logic [3:0]        pins_q;

  assign is_wr  = (req_op == OP_WRITE);
  assign is_rd  = (req_op == OP_READ);
  assign is_pre = (req_op == OP_PRE);
  assign fire   = req_valid && req_ready;

  // column bits fill the address pins around the auto-precharge pin
  for (genvar g = 0; g < ADDR_W; g++) begin : g_addr
    localparam int SRC = (g < AP_BIT) ? g : g - 1;
    if (g == AP_BIT) begin : g_ap
      assign addr_pack[g] = req_ap;
    end else if (SRC < COL_W) begin : g_col
      assign addr_pack[g] = req_col[SRC];
    end else begin : g_zero
      assign addr_pack[g] = 1'b0;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_sel[b] = (req_bank == BANK_W'(b));
    wr_bank_recovery #(.WL(WL), .NIB(NIB), .TWR(TWR)) u_rec (
      .clk      (clk),
      .rst      (rst),
      .wr_hit   (fire && is_wr && bank_sel[b]),
      .wr_ap    (req_ap),
      .pre_hit  (fire && is_pre && bank_sel[b] && !ap_closed[b]),
      .pre_ok   (pre_ok[b]),
      .ap_closed(ap_closed[b])
    );
  end

  wr_col_spacer #(.NIB(NIB)) u_space (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (fire && is_wr),
    .col_hit(fire && (is_wr || is_rd)),
    .col_ok (col_ok)
  );

  assign ap_sel     = ap_closed[req_bank];
  assign pre_ok_sel = pre_ok[req_bank];

  always_comb begin
    case (req_op)
      OP_WRITE, OP_READ: req_ready = col_ok;
      OP_PRE:            req_ready = ap_sel || pre_ok_sel;
      default:           req_ready = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q  <= PINS_NOP;
      sd_addr <= '0;
      sd_ba   <= '0;
    end else begin
      pins_q  <= PINS_NOP;
      sd_addr <= '0;
      sd_ba   <= '0;
      if (fire) begin
        case (req_op)
          OP_WRITE: begin
            pins_q  <= PINS_WRITE;
            sd_addr <= addr_pack;
            sd_ba   <= req_bank;
          end
          OP_READ: begin
            pins_q  <= PINS_READ;
            sd_addr <= addr_pack;
            sd_ba   <= req_bank;
          end
          OP_PRE: begin
            if (!ap_sel) begin
              pins_q <= PINS_PRE;
              sd_ba  <= req_bank;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins_q;

  assert_idle_nop_R1: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == PINS_NOP && sd_addr == '0));

  assert_ap_bit_R4: assert property (@(posedge clk) disable iff (rst)
    (fire && (is_wr || is_rd)) |=> sd_addr[AP_BIT] == $past(req_ap));

  assert_ap_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (fire && is_pre && ap_sel) |=> {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == PINS_NOP);

  assert_write_pins_R2: assert property (@(posedge clk) disable iff (rst)
    (fire && is_wr) |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == PINS_WRITE
                         && sd_ba == $past(req_bank)));
endmodule

// File: tb/wr_cmd_seq_tb.sv
`timescale 1ns/1ps
module wr_cmd_seq_tb;
  localparam int WL = 3, BL = 8, NIB = BL / 4, TWR = 4;
  localparam logic [3:0] P_NOP = 4'b0111, P_WR = 4'b0100, P_RD = 4'b0101, P_PRE = 4'b0010;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ap = 1'b0;
  logic [1:0] req_op = 2'd0, req_bank = 2'd0;
  logic [8:0] req_col = '0;
  logic req_ready, cs_n, ras_n, cas_n, we_n;
  logic [11:0] addr;
  logic [1:0] ba;

  always #10 clk = ~clk;

  wr_cmd_seq #(.BURST_LEN(BL), .WL(WL), .TWR(TWR)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bank(req_bank), .req_col(req_col), .req_ap(req_ap),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_addr(addr), .sd_ba(ba));

  int tests = 0, fails = 0;
  string phase = "R1";
  int cyc = 0, acc_cyc = -1, last_wr = -1000;
  int bwr [4];
  bit bap [4];
  logic [3:0]  exp_pins = P_NOP;
  logic [11:0] exp_addr = '0;
  logic [1:0]  exp_ba = '0;

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit mready(logic [1:0] op, logic [1:0] b, int e);
    case (op)
      2'd0, 2'd1: return (e - last_wr) >= NIB;
      2'd2:       return bap[b] || ((e - bwr[b]) >= WL + NIB + TWR);
      default:    return 1'b1;
    endcase
  endfunction

  // reference model, advanced on each edge
  always @(posedge clk) begin
    if (rst) begin
      cyc = 0; last_wr = -1000;
      for (int i = 0; i < 4; i++) begin bwr[i] = -1000; bap[i] = 1'b0; end
      exp_pins = P_NOP; exp_addr = '0; exp_ba = '0;
    end else begin
      int e;
      e = cyc + 1;
      exp_pins = P_NOP; exp_addr = '0; exp_ba = '0;
      if (req_valid && mready(req_op, req_bank, e)) begin
        acc_cyc = e;
        case (req_op)
          2'd0, 2'd1: begin
            exp_pins = (req_op == 2'd0) ? P_WR : P_RD;
            exp_addr = {2'b00, req_col[8], req_ap, req_col[7:0]};
            exp_ba   = req_bank;
            if (req_op == 2'd0) begin
              last_wr = e; bwr[req_bank] = e; bap[req_bank] = req_ap;
            end
          end
          2'd2: if (!bap[req_bank]) begin exp_pins = P_PRE; exp_ba = req_bank; end
          default: ;
        endcase
      end
      cyc = e;
    end
  end

  // compare every cycle, away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(phase, "pins", {cs_n, ras_n, cas_n, we_n}, exp_pins);
      chk(phase, "addr", addr, exp_addr);
      chk(phase, "bank", ba, exp_ba);
      chk(phase, "ready", req_ready, mready(req_op, req_bank, cyc + 1));
    end
  end

  // drive right after an edge; returns right after the accepting edge
  task automatic issue(logic [1:0] op, logic [1:0] b, logic [8:0] col, logic ap,
                       output int at);
    req_valid = 1'b1; req_op = op; req_bank = b; req_col = col; req_ap = ap;
    do begin @(posedge clk); #1; end while (acc_cyc != cyc);
    at = acc_cyc;
    req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t0, t1, t2;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle(2);
    #8;
    phase = "R1";
    chk("R1", "reset pins NOP", {cs_n, ras_n, cas_n, we_n}, P_NOP);
    chk("R1", "reset addr", addr, 0);
    @(posedge clk); #1;

    phase = "R2"; issue(2'd0, 2'd1, 9'h1A5, 1'b0, t0); idle(3);
    phase = "R3"; issue(2'd0, 2'd2, 9'h0FF, 1'b1, t0); idle(3);
    phase = "R4"; issue(2'd0, 2'd3, 9'h133, 1'b1, t0); idle(4);

    phase = "R5";
    issue(2'd0, 2'd0, 9'h155, 1'b0, t0);
    issue(2'd0, 2'd3, 9'h0AA, 1'b0, t1);
    chk("R5", "write spacing", t1 - t0, NIB);

    phase = "R6";
    issue(2'd1, 2'd3, 9'h101, 1'b1, t2);
    chk("R6", "read after write spacing", t2 - t1, NIB);

    phase = "R7";
    issue(2'd2, 2'd0, 9'h000, 1'b0, t2);
    chk("R7", "precharge after recovery", t2 - t0, WL + NIB + TWR);

    phase = "R8";
    issue(2'd0, 2'd1, 9'h022, 1'b0, t0);
    issue(2'd2, 2'd0, 9'h000, 1'b0, t1);
    chk("R8", "other bank precharge delay", t1 - t0, 1);

    phase = "R9";
    issue(2'd2, 2'd2, 9'h000, 1'b0, t0);
    #8 chk("R9", "dropped precharge pins", {cs_n, ras_n, cas_n, we_n}, P_NOP);
    @(posedge clk); #1;

    phase = "R10";
    issue(2'd3, 2'd1, 9'h1FF, 1'b1, t0);
    #8 chk("R10", "reserved op pins", {cs_n, ras_n, cas_n, we_n}, P_NOP);
    @(posedge clk); #1;

    phase = "R11";
    idle(12);
    issue(2'd0, 2'd1, 9'h011, 1'b0, t0);
    idle(3);
    issue(2'd0, 2'd1, 9'h012, 1'b0, t1);
    issue(2'd2, 2'd1, 9'h000, 1'b0, t2);
    chk("R11", "recovery restarted", t2 - t1, WL + NIB + TWR);

    idle(5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule